// File: doc/BRIEF.md
# LPC Peripheral Cycle Engine

This block is the target side of a Low Pin Count bus. On every rising edge of the bus clock it samples the four multiplexed LAD lines and the frame strobe. It recognises a cycle start and decodes the cycle kind and direction. It then collects the address, or the DMA channel and size, and answers with turnaround, SYNC and data nibbles through a tri-state LAD driver that has a separate output enable. Six single-byte cycle kinds are served: I/O and memory accesses in both directions, and DMA transfers in both directions.

Positive decoding applies to I/O and memory accesses. The engine claims an access only when its address falls inside a parameterised window. For DMA it claims a cycle only when the addressed channel has a pending request. In every other case it keeps its LAD driver off until the next start. Register accesses appear on a simple strobe bus: an address, write data, read data, a write pulse, a read pulse and a memory/I/O flag. DMA transfers appear on a per-channel acknowledge vector, which shares the write-data path with the register bus.

Top module: `lpc_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine returns to idle. From the next cycle `lad_oe`, `bus_wr`, `bus_rd` and `dma_ack` are all low.
- R2: A start is the frame strobe low with LAD = 0000b. The next nibble selects the cycle kind: 0000b I/O read, 0010b I/O write, 0100b memory read, 0110b memory write, 1000b DMA with the byte supplied by the host, 1010b DMA with the byte supplied by the device. Any other kind nibble is ignored, and LAD stays undriven until the next start.
- R3: I/O cycles carry a 16-bit address, most significant nibble first. An address inside the I/O window (base `IO_BASE`, 2^`IO_SPAN_LOG2` bytes) is claimed. An I/O write gives one `bus_wr` pulse, with `bus_addr` and `bus_wdata` valid, in the first host turnaround clock. The data byte arrives low nibble first.
- R4: An I/O or memory address outside its window leaves `lad_oe` low for the whole cycle and produces no strobe.
- R5: Memory cycles carry a 32-bit address, most significant nibble first, and are claimed inside the window `MEM_BASE` / 2^`MEM_SPAN_LOG2`. Their strobes assert `bus_mem` = 1. I/O strobes assert `bus_mem` = 0.
- R6: A claimed cycle follows two host turnaround clocks. The engine then drives `LONG_WAITS` long-wait SYNC nibbles (0110b) and one ready SYNC (0000b). For device-supplied data it next drives the byte low nibble first. It ends with two clocks of 1111b and then releases LAD.
- R7: An I/O or memory read gives one `bus_rd` pulse in the first host turnaround clock. `bus_rdata` is sampled in the following clock.
- R8: In a DMA cycle the nibble after the kind holds the channel in bits [2:0], and the following nibble holds the size. A channel whose `dma_req` bit is high is claimed. `dma_ack` pulses one-hot for that channel in the first host turnaround clock, with `dma_to_dev` = 1 for kind 1000b. For 1010b the byte is taken from `dma_rdata` in the following clock.
- R9: A DMA cycle that addresses a channel with no request, or a channel number of `DMA_CHANNELS` or above, is ignored: no acknowledge, and LAD stays undriven.
- R10: For a DMA size nibble of 01b (16-bit) or 11b (32-bit), only the first byte is transferred. It is closed with the ready SYNC 0000b and one acknowledge. Later nibbles with the frame strobe high, including 0000b, neither start a cycle nor drive LAD.
- R11: A frame strobe sampled low in the middle of a cycle aborts it. From the next clock LAD is released and no strobe fires. If that nibble was 0000b, it counts as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Sampled LAD nibble |
| lad_out | output | 4 | Nibble to drive on LAD |
| lad_oe | output | 1 | LAD driver enable |
| bus_addr | output | 32 | Access address (I/O zero-extended) |
| bus_wdata | output | 8 | Write byte, also used for host-to-device DMA |
| bus_rdata | input | 8 | Read byte, valid the clock after `bus_rd` |
| bus_wr | output | 1 | Register write pulse |
| bus_rd | output | 1 | Register read pulse |
| bus_mem | output | 1 | 1 for a memory access, 0 for I/O |
| dma_req | input | DMA_CHANNELS | Per-channel pending DMA request |
| dma_ack | output | DMA_CHANNELS | One-hot DMA transfer pulse |
| dma_to_dev | output | 1 | Direction of the acknowledged transfer |
| dma_rdata | input | 8 | Device byte, valid the clock after `dma_ack` |

## Verification
The hardest situations to reach are cycles that leave the bus shortly after they start. Examples are a multi-byte DMA request whose extra host nibbles arrive after the engine has let go of LAD, and a frame-strobe abort that lands in the middle of the SYNC phase. The stimulus builds each cycle nibble by nibble from a description of the cycle and can place an abort at any clock. After a truncated DMA burst it follows up with trailing 0000b nibbles while the frame strobe is high, which an engine that mistook them for a start would answer.

// File: rtl/lpc_tgt_pkg.sv
// Shared types and nibble codes for the LPC peripheral cycle engine.
// Assumes a single clock domain; all values are bus nibbles.
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CTYPE, ST_ADDR, ST_CHAN, ST_SIZE,
        ST_HDAT_LO, ST_HDAT_HI, ST_HTAR1, ST_HTAR2, ST_SYNC,
        ST_TDAT_LO, ST_TDAT_HI, ST_TTAR1, ST_TTAR2, ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {SP_IO, SP_MEM, SP_DMA, SP_NONE} space_e;

    typedef struct packed {
        logic   valid;
        space_e space;
        logic   host_src;   // host supplies the data byte
    } cyc_kind_t;

    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_WAIT  = 4'h6;
    localparam logic [3:0] NIB_READY = 4'h0;
    localparam logic [3:0] NIB_TAR   = 4'hF;

    localparam logic [3:0] KIND_IO_RD  = 4'h0;
    localparam logic [3:0] KIND_IO_WR  = 4'h2;
    localparam logic [3:0] KIND_MEM_RD = 4'h4;
    localparam logic [3:0] KIND_MEM_WR = 4'h6;
    localparam logic [3:0] KIND_DMA_HD = 4'h8;
    localparam logic [3:0] KIND_DMA_DH = 4'hA;

endpackage

// File: rtl/lpc_tgt_ctdec.sv
// Cycle-kind decoder: maps the nibble after a start to a space and a
// data direction. Assumes unknown nibbles must be ignored.
module lpc_tgt_ctdec
    import lpc_tgt_pkg::*;
(
    input  logic [3:0] nib,
    output cyc_kind_t  kind
);

    // Decode the six served cycle kinds; everything else is invalid.
    always_comb begin
        kind = '{valid: 1'b0, space: SP_NONE, host_src: 1'b0};
        case (nib)
            KIND_IO_RD:  kind = '{valid: 1'b1, space: SP_IO,  host_src: 1'b0};
            KIND_IO_WR:  kind = '{valid: 1'b1, space: SP_IO,  host_src: 1'b1};
            KIND_MEM_RD: kind = '{valid: 1'b1, space: SP_MEM, host_src: 1'b0};
            KIND_MEM_WR: kind = '{valid: 1'b1, space: SP_MEM, host_src: 1'b1};
            KIND_DMA_HD: kind = '{valid: 1'b1, space: SP_DMA, host_src: 1'b1};
            KIND_DMA_DH: kind = '{valid: 1'b1, space: SP_DMA, host_src: 1'b0};
            default:     kind = '{valid: 1'b0, space: SP_NONE, host_src: 1'b0};
        endcase
    end

endmodule

// File: rtl/lpc_tgt_match.sv
// Claim logic: positive decode of the I/O and memory windows and the
// per-channel DMA request check. Assumes window sizes are powers of two
// and aligned bases. The returned ack vector is one-hot or zero.
module lpc_tgt_match
    import lpc_tgt_pkg::*;
#(
    parameter logic [15:0] IO_BASE       = 16'h02E8,
    parameter int unsigned IO_SPAN_LOG2  = 3,
    parameter logic [31:0] MEM_BASE      = 32'hFED0_0000,
    parameter int unsigned MEM_SPAN_LOG2 = 12,
    parameter int unsigned DMA_CHANNELS  = 4
) (
    input  space_e                  space,
    input  logic [31:0]             addr,
    input  logic [2:0]              chan,
    input  logic [DMA_CHANNELS-1:0] dma_req,
    output logic [DMA_CHANNELS-1:0] ack_vec,
    output logic                    hit
);

    logic io_hit;
    logic mem_hit;

    // Window compares on the address bits above each span.
    assign io_hit  = (space == SP_IO)
                   && (addr[15:IO_SPAN_LOG2] == IO_BASE[15:IO_SPAN_LOG2]);
    assign mem_hit = (space == SP_MEM)
                   && (addr[31:MEM_SPAN_LOG2] == MEM_BASE[31:MEM_SPAN_LOG2]);

    // One select per implemented channel; absent channels never match.
    for (genvar i = 0; i < DMA_CHANNELS; i++) begin : g_chan
        assign ack_vec[i] = (space == SP_DMA) && (chan == 3'(i)) && dma_req[i];
    end

    assign hit = io_hit || mem_hit || (|ack_vec);

endmodule

// File: rtl/lpc_tgt_drive.sv
// LAD output stage: selects the nibble and enable for each response
// phase. Assumes the state and counters come from registers.
module lpc_tgt_drive
    import lpc_tgt_pkg::*;
#(
    parameter int unsigned LONG_WAITS = 2,
    parameter int unsigned WCW        = 2
) (
    input  tgt_state_e     state,
    input  logic [WCW-1:0] wait_cnt,
    input  logic [7:0]     rdata,
    output logic [3:0]     lad_out,
    output logic           lad_oe
);

    // Drive SYNC, data and the closing turnaround; float otherwise.
    always_comb begin
        lad_oe  = 1'b1;
        lad_out = NIB_TAR;
        case (state)
            ST_SYNC:    lad_out = (wait_cnt < WCW'(LONG_WAITS)) ? NIB_WAIT : NIB_READY;
            ST_TDAT_LO: lad_out = rdata[3:0];
            ST_TDAT_HI: lad_out = rdata[7:4];
            ST_TTAR1,
            ST_TTAR2:   lad_out = NIB_TAR;
            default:    lad_oe  = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpc_target.sv
// LPC peripheral cycle engine. Decodes single-byte I/O, memory and DMA
// cycles, raises register or DMA strobes in the first host turnaround
// clock, and answers with SYNC, data and turnaround nibbles.
// Assumes: single clock, synchronous active-low reset, LAD tri-state
// buffer outside this block, at most 8 DMA channels.
module lpc_target
    import lpc_tgt_pkg::*;
#(
    parameter logic [15:0] IO_BASE       = 16'h02E8,
    parameter int unsigned IO_SPAN_LOG2  = 3,
    parameter logic [31:0] MEM_BASE      = 32'hFED0_0000,
    parameter int unsigned MEM_SPAN_LOG2 = 12,
    parameter int unsigned DMA_CHANNELS  = 4,
    parameter int unsigned LONG_WAITS    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lframe_n,
    input  logic [3:0]              lad_in,
    output logic [3:0]              lad_out,
    output logic                    lad_oe,
    output logic [31:0]             bus_addr,
    output logic [7:0]              bus_wdata,
    input  logic [7:0]              bus_rdata,
    output logic                    bus_wr,
    output logic                    bus_rd,
    output logic                    bus_mem,
    input  logic [DMA_CHANNELS-1:0] dma_req,
    output logic [DMA_CHANNELS-1:0] dma_ack,
    output logic                    dma_to_dev,
    input  logic [7:0]              dma_rdata
);

    localparam int unsigned WCW      = (LONG_WAITS < 1) ? 1 : $clog2(LONG_WAITS + 1);
    localparam logic [2:0]  IO_NIBS  = 3'd3;   // nibbles left after the first
    localparam logic [2:0]  MEM_NIBS = 3'd7;

    tgt_state_e              state_q, state_d;
    space_e                  space_q;
    logic                    host_src_q;
    logic [31:0]             addr_q;
    logic [2:0]              chan_q;
    logic [7:0]              wdata_q;
    logic [7:0]              rdata_q;
    logic [2:0]              nib_cnt_q;
    logic [WCW-1:0]          wait_cnt_q;
    cyc_kind_t               ct_kind;
    logic [DMA_CHANNELS-1:0] ack_vec;
    logic                    hit;
    logic                    claim;

    lpc_tgt_ctdec u_ctdec (
        .nib  (lad_in),
        .kind (ct_kind)
    );

    lpc_tgt_match #(
        .IO_BASE       (IO_BASE),
        .IO_SPAN_LOG2  (IO_SPAN_LOG2),
        .MEM_BASE      (MEM_BASE),
        .MEM_SPAN_LOG2 (MEM_SPAN_LOG2),
        .DMA_CHANNELS  (DMA_CHANNELS)
    ) u_match (
        .space   (space_q),
        .addr    (addr_q),
        .chan    (chan_q),
        .dma_req (dma_req),
        .ack_vec (ack_vec),
        .hit     (hit)
    );

    lpc_tgt_drive #(
        .LONG_WAITS (LONG_WAITS),
        .WCW        (WCW)
    ) u_drive (
        .state    (state_q),
        .wait_cnt (wait_cnt_q),
        .rdata    (rdata_q),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe)
    );

    // Next-state selection; a low frame strobe overrides every phase.
    always_comb begin
        state_d = state_q;
        if (!lframe_n) begin
            state_d = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            case (state_q)
                ST_CTYPE: begin
                    if (!ct_kind.valid)              state_d = ST_IGNORE;
                    else if (ct_kind.space == SP_DMA) state_d = ST_CHAN;
                    else                              state_d = ST_ADDR;
                end
                ST_ADDR: begin
                    if (nib_cnt_q == 3'd0)
                        state_d = host_src_q ? ST_HDAT_LO : ST_HTAR1;
                end
                ST_CHAN:    state_d = ST_SIZE;
                ST_SIZE:    state_d = host_src_q ? ST_HDAT_LO : ST_HTAR1;
                ST_HDAT_LO: state_d = ST_HDAT_HI;
                ST_HDAT_HI: state_d = ST_HTAR1;
                ST_HTAR1:   state_d = hit ? ST_HTAR2 : ST_IGNORE;
                ST_HTAR2:   state_d = ST_SYNC;
                ST_SYNC: begin
                    if (wait_cnt_q == WCW'(LONG_WAITS))
                        state_d = host_src_q ? ST_TTAR1 : ST_TDAT_LO;
                end
                ST_TDAT_LO: state_d = ST_TDAT_HI;
                ST_TDAT_HI: state_d = ST_TTAR1;
                ST_TTAR1:   state_d = ST_TTAR2;
                ST_TTAR2:   state_d = ST_IDLE;
                default:    state_d = state_q;
            endcase
        end
    end

    // State register with synchronous bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Field capture: kind, address, channel, data bytes and wait count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q    <= SP_NONE;
            host_src_q <= 1'b0;
            addr_q     <= '0;
            chan_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            nib_cnt_q  <= '0;
            wait_cnt_q <= '0;
        end else if (lframe_n) begin
            case (state_q)
                ST_CTYPE: begin
                    space_q    <= ct_kind.space;
                    host_src_q <= ct_kind.host_src;
                    addr_q     <= '0;
                    nib_cnt_q  <= (ct_kind.space == SP_MEM) ? MEM_NIBS : IO_NIBS;
                end
                ST_ADDR: begin
                    addr_q <= {addr_q[27:0], lad_in};
                    if (nib_cnt_q != 3'd0) nib_cnt_q <= nib_cnt_q - 3'd1;
                end
                ST_CHAN:    chan_q        <= lad_in[2:0];
                ST_HDAT_LO: wdata_q[3:0]  <= lad_in;
                ST_HDAT_HI: wdata_q[7:4]  <= lad_in;
                ST_HTAR2: begin
                    wait_cnt_q <= '0;
                    if (!host_src_q)
                        rdata_q <= (space_q == SP_DMA) ? dma_rdata : bus_rdata;
                end
                ST_SYNC: begin
                    if (wait_cnt_q != WCW'(LONG_WAITS)) wait_cnt_q <= wait_cnt_q + WCW'(1);
                end
                default: ;
            endcase
        end
    end

    // Strobes fire only in the first host turnaround clock of a claim.
    assign claim      = (state_q == ST_HTAR1) && hit;
    assign bus_wr     = claim && (space_q != SP_DMA) && host_src_q;
    assign bus_rd     = claim && (space_q != SP_DMA) && !host_src_q;
    assign dma_ack    = claim ? ack_vec : '0;
    assign bus_addr   = addr_q;
    assign bus_wdata  = wdata_q;
    assign bus_mem    = (space_q == SP_MEM);
    assign dma_to_dev = host_src_q;

endmodule

// File: rtl/lpc_target_chk.sv
// Assertion checker for lpc_target, attached through bind below.
// Assumes the bench holds reset low for the first clock edges.
module lpc_target_chk #(
    parameter int unsigned DMA_CHANNELS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lframe_n,
    input logic [3:0]              lad_out,
    input logic                    lad_oe,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [DMA_CHANNELS-1:0] dma_req,
    input logic [DMA_CHANNELS-1:0] dma_ack
);

    // R1: reset leaves LAD undriven on the following clock.
    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> !lad_oe);

    // R8: at most one channel acknowledged at a time.
    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_ack));

    // R9: no acknowledge for a channel without a request.
    assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack & ~dma_req) == '0);

    // R7: register strobes and DMA acknowledge are mutually exclusive.
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd) && !((bus_wr || bus_rd) && (dma_ack != '0)));

    // R11: a low frame strobe silences the engine on the next clock.
    assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> (!lad_oe && !bus_wr && !bus_rd && (dma_ack == '0)));

    // R6: a strobe is followed by a host turnaround clock, not a drive.
    assert_strobe_then_listen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd || (dma_ack != '0)) |=> !lad_oe);

    // R6: a normal release is preceded by a 1111b turnaround nibble.
    assert_release_after_tar_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lad_oe) && $past(lframe_n)) |-> ($past(lad_out) == 4'hF));

endmodule

bind lpc_target lpc_target_chk #(.DMA_CHANNELS(DMA_CHANNELS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lframe_n (lframe_n),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .dma_req  (dma_req),
    .dma_ack  (dma_ack)
);

// File: tb/lpc_target_tb_top.sv
// Scoreboard bench: the driver task builds each cycle nibble by nibble
// and queues the expected observation per clock; the monitor compares.
module lpc_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_wr, bus_rd, bus_mem;
    logic [3:0]  dma_req = 4'b0110;
    logic [3:0]  dma_ack;
    logic        dma_to_dev;
    logic [7:0]  dma_rdata = 8'h3C;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic        oe;
        logic [3:0]  lad;
        logic        wr, rd, mem, to_dev;
        logic [3:0]  ack;
        logic [31:0] addr;
        logic [7:0]  wdata;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register file model: read byte derived from the address.
    assign bus_rdata = bus_addr[7:0] ^ 8'h5A;

    lpc_target dut_i (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_mem(bus_mem), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_to_dev(dma_to_dev), .dma_rdata(dma_rdata)
    );

    function automatic exp_t blank(input string tag);
        exp_t e;
        e.oe = 0; e.lad = 0; e.wr = 0; e.rd = 0; e.mem = 0; e.to_dev = 0;
        e.ack = 0; e.addr = 0; e.wdata = 0; e.tag = tag;
        return e;
    endfunction

    task automatic step(input logic fr, input logic [3:0] nib, input exp_t e);
        @(negedge clk);
        lframe_n = fr;
        lad_in   = nib;
        sbq.push_back(e);
    endtask

    // Monitor: compare one queued observation a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sbq.size() > 0) begin
            exp_t e;
            logic bad;
            e = sbq.pop_front();
            bad = (lad_oe !== e.oe) || (e.oe && lad_out !== e.lad)
                || (bus_wr !== e.wr) || (bus_rd !== e.rd) || (dma_ack !== e.ack)
                || ((e.wr || e.rd) && (bus_addr !== e.addr || bus_mem !== e.mem))
                || (e.wr && bus_wdata !== e.wdata)
                || ((e.ack != 0) && (dma_to_dev !== e.to_dev))
                || ((e.ack != 0) && e.to_dev && bus_wdata !== e.wdata);
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s: got oe=%b lad=%h wr=%b rd=%b ack=%b addr=%h mem=%b wd=%h dir=%b exp oe=%b lad=%h wr=%b rd=%b ack=%b addr=%h mem=%b wd=%h dir=%b",
                    e.tag, lad_oe, lad_out, bus_wr, bus_rd, dma_ack, bus_addr, bus_mem,
                    bus_wdata, dma_to_dev, e.oe, e.lad, e.wr, e.rd, e.ack, e.addr,
                    e.mem, e.wdata, e.to_dev);
            end
        end
    end

    // Driver: one full cycle with expected per-clock behaviour.
    task automatic txn(input logic [3:0] ct, input logic [31:0] a, input logic [2:0] ch,
                       input logic [1:0] sz, input logic [7:0] wd, input logic hit,
                       input int abort_k, input logic [3:0] trail, input string tag);
        logic is_io, is_mem, is_dma, hsrc;
        int   H, s0, tar1, last, tt;
        logic [7:0] rb;
        is_io  = (ct == 4'h0) || (ct == 4'h2);
        is_mem = (ct == 4'h4) || (ct == 4'h6);
        is_dma = (ct == 4'h8) || (ct == 4'hA);
        hsrc   = is_dma ? !ct[1] : ct[1];
        H      = is_io ? 4 : (is_mem ? 8 : (is_dma ? 2 : 0));
        s0     = hsrc ? 6 + H : 4 + H;
        tar1   = hsrc ? 4 + H : 2 + H;
        tt     = hsrc ? s0 + W + 1 : s0 + W + 3;
        last   = 12 + H + W;
        rb     = is_dma ? dma_rdata : (a[7:0] ^ 8'h5A);
        for (int k = 0; k <= last; k++) begin
            logic fr;
            logic [3:0] nib;
            int c;
            exp_t e;
            fr = 1'b1; nib = 4'hF;
            if (k == 0) begin fr = 1'b0; nib = 4'h0; end
            else if (k == 1) nib = ct;
            else if (k <= 1 + H) begin
                if (is_dma) nib = (k == 2) ? {1'b0, ch} : {2'b00, sz};
                else        nib = a[4*(H-1-(k-2)) +: 4];
            end
            else if (hsrc && k == 2 + H) nib = wd[3:0];
            else if (hsrc && k == 3 + H) nib = wd[7:4];
            else if (k > 8 + H + W)      nib = trail;
            if (k == abort_k) begin fr = 1'b0; nib = 4'hF; end
            c = k + 1;
            e = blank(tag);
            if (hit && !(abort_k >= 0 && c > abort_k)) begin
                if (c == tar1) begin
                    e.wdata = wd;
                    if (is_dma) begin
                        e.ack = 4'(1 << ch); e.to_dev = hsrc;
                    end else begin
                        e.wr = hsrc; e.rd = !hsrc; e.mem = is_mem;
                        e.addr = is_mem ? a : {16'h0, a[15:0]};
                    end
                end
                if (c >= s0 && c < s0 + W) begin e.oe = 1; e.lad = 4'h6; end
                if (c == s0 + W)           begin e.oe = 1; e.lad = 4'h0; end
                if (!hsrc && c == s0 + W + 1) begin e.oe = 1; e.lad = rb[3:0]; end
                if (!hsrc && c == s0 + W + 2) begin e.oe = 1; e.lad = rb[7:4]; end
                if (c == tt || c == tt + 1)   begin e.oe = 1; e.lad = 4'hF; end
            end
            step(fr, nib, e);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        #(CLK_PERIOD/4);
        checks++;  // R1: reset state
        if (lad_oe !== 1'b0 || bus_wr !== 1'b0 || bus_rd !== 1'b0 || dma_ack !== 4'b0) begin
            fails++;
            $display("FAIL R1: oe=%b wr=%b rd=%b ack=%b expected all zero",
                     lad_oe, bus_wr, bus_rd, dma_ack);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R3 I/O write hit, R6 response shape
        txn(4'h2, 32'h02EA, 0, 0, 8'hA5, 1, -1, 4'hF, "R3_io_write");
        // R7 I/O read hit, data low nibble first (R6)
        txn(4'h0, 32'h02EF, 0, 0, 8'h00, 1, -1, 4'hF, "R7_io_read");
        // R4 misses just outside the window on each side
        txn(4'h2, 32'h02F0, 0, 0, 8'h11, 0, -1, 4'hF, "R4_io_write_miss");
        txn(4'h0, 32'h02E7, 0, 0, 8'h00, 0, -1, 4'hF, "R4_io_read_miss");
        // R5 memory cycles
        txn(4'h6, 32'hFED0_0123, 0, 0, 8'h9C, 1, -1, 4'hF, "R5_mem_write");
        txn(4'h4, 32'hFED0_0FFF, 0, 0, 8'h00, 1, -1, 4'hF, "R5_mem_read");
        txn(4'h4, 32'hFED1_0000, 0, 0, 8'h00, 0, -1, 4'hF, "R4_mem_miss");
        // R8 DMA both directions on requesting channels
        txn(4'h8, 32'h0, 3'd1, 2'b00, 8'h4E, 1, -1, 4'hF, "R8_dma_to_dev");
        txn(4'hA, 32'h0, 3'd2, 2'b00, 8'h00, 1, -1, 4'hF, "R8_dma_from_dev");
        // R9 channel without request, channel not implemented
        txn(4'h8, 32'h0, 3'd3, 2'b00, 8'h77, 0, -1, 4'hF, "R9_no_request");
        dma_req = 4'b1111;
        txn(4'hA, 32'h0, 3'd5, 2'b00, 8'h00, 0, -1, 4'hF, "R9_bad_channel");
        dma_req = 4'b0110;
        // R10 multi-byte DMA sizes truncated; trailing 0000b must not start
        txn(4'h8, 32'h0, 3'd1, 2'b01, 8'hC3, 1, -1, 4'h0, "R10_dma16");
        txn(4'hA, 32'h0, 3'd2, 2'b11, 8'h00, 1, -1, 4'h0, "R10_dma32");
        // R2 unsupported kinds ignored, then a valid cycle is still served
        txn(4'hC, 32'h0, 0, 0, 8'h00, 0, -1, 4'hF, "R2_kind_C");
        txn(4'h1, 32'h0, 0, 0, 8'h00, 0, -1, 4'hF, "R2_kind_1");
        txn(4'h2, 32'h02E8, 0, 0, 8'h3B, 1, -1, 4'hF, "R2_after_ignore");
        // R11 abort during SYNC of a read and during address of a write
        txn(4'h0, 32'h02E9, 0, 0, 8'h00, 1, 8, 4'hF, "R11_abort_sync");
        txn(4'h2, 32'h02EB, 0, 0, 8'h66, 1, 3, 4'hF, "R11_abort_addr");
        txn(4'hA, 32'h0, 3'd1, 2'b00, 8'h00, 1, 4, 4'hF, "R11_abort_dma_tar");
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule